// File: doc/BRIEF.md
# RTC Power-Fail Write Lockout Controller

This block guards the clock/calendar registers and the battery-backed RAM of a real-time clock while main power is lost and restored. It watches a digital supply-low flag from an external comparator, two battery-health flags, the system reset line and a slow 62.5 ms timebase tick. From these it drives one lockout signal. That signal masks the host write strobe, the host read strobe and the reset line before they reach the clock and RAM. The lockout holds while main power is low. It also holds for a bounded window after power returns, while the valid-RAM-and-time bit is 0, and while the clock divider is set to anything other than normal operation.

The block also applies two battery-fault rules. The first: a battery below 1 V seen together with a high system reset produces a single-cycle pulse, which clears registers 00 to 0D. The second: a battery that goes missing while main power is off clears the valid-RAM-and-time bit when power comes back, and no other state is touched. All interfaces are plain control and status pins. There is no data stream, so no valid/ready handshake and no back-pressure.

Top module: `rtc_pwr_guard`

## Requirements
- R1: `lock_o` is 1 in every cycle in which `vcc_low_i` is 1, with no register delay.
- R2: Each of `wr_o`, `rd_o` and `rtc_rst_o` equals its input strobe (`host_wr_i`, `host_rd_i`, `sys_reset_i`) ANDed with the inverse of `lock_o`, combinationally.
- R3: After `vcc_low_i` falls to 0, the restore hold keeps `lock_o` at 1 until the second `tick_i` pulse sampled with `vcc_low_i` at 0, and releases on the clock edge after it. With a 40-cycle tick this is 40 to 81 cycles. The same hold is active when the block comes out of `rst_n`.
- R4: `clr_regs_o` pulses for exactly one cycle, one clock after `batt_dead_i & sys_reset_i` is first sampled at 1. It does not pulse again until that condition has been sampled at 0 and then rises again.
- R5: If `batt_ok_i` is sampled at 0 in any cycle while `vcc_low_i` is 1, then `vrt_o` goes to 0 on the clock edge that samples `vcc_low_i` back at 0. This causes no `clr_regs_o` pulse.
- R6: If the battery stays valid through a power loss, `vrt_o` stays at 1. Once `vrt_o` is 0, it returns to 1 only through `rst_n`, which sets it to 1.
- R7: `lock_o` is 1 whenever `vrt_o` is 0.
- R8: `lock_o` is 1 whenever `div_mode_i` differs from the normal-operation code 3'b010, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| vcc_low_i | input | 1 | Main supply below about 4.0 V (comparator output, 1 = low) |
| batt_dead_i | input | 1 | Battery below about 1 V |
| batt_ok_i | input | 1 | Battery present and valid |
| sys_reset_i | input | 1 | System reset line, active high |
| host_wr_i | input | 1 | Host/microcontroller write strobe |
| host_rd_i | input | 1 | Host/microcontroller read strobe |
| tick_i | input | 1 | One-cycle pulse every 62.5 ms |
| div_mode_i | input | 3 | Divider-control field; 3'b010 = normal operation |
| lock_o | output | 1 | Lockout active |
| wr_o | output | 1 | Write strobe passed to RTC/RAM |
| rd_o | output | 1 | Read strobe passed to RTC/RAM |
| rtc_rst_o | output | 1 | Reset passed to RTC/RAM |
| clr_regs_o | output | 1 | One-cycle clear for registers 00 to 0D |
| vrt_o | output | 1 | Valid-RAM-and-time bit |

## Verification
The lockout and the gated strobes are combinational in `vcc_low_i`, `div_mode_i` and the stored state. The bench therefore drives each input on a falling edge and checks the effect one time unit later, in the same cycle. The clear pulse and the valid bit are registered and are due one clock after the condition is sampled. The bench counts pulses at every falling edge over a window, so it sees exactly one sample per pulse. The restore release depends on where the tick falls, so the bench restores power at several chosen tick phases. It counts falling edges until `lock_o` drops and checks that count against the 40-to-81-cycle window.

// File: rtl/rtc_pwr_pkg.sv
package rtc_pwr_pkg;
  typedef logic [2:0] div_mode_t;
  localparam div_mode_t DIV_NORMAL = 3'b010;
  localparam int unsigned STRB_N = 3;
  typedef enum int unsigned {STRB_WR = 0, STRB_RD = 1, STRB_RST = 2} strb_idx_e;
endpackage

// File: rtl/rtc_restore_timer.sv
module rtc_restore_timer #(
  parameter int unsigned HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_low_i,
  input  logic tick_i,
  output logic hold_o
);
  localparam int unsigned CW = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          hold_q;

  // Hold is armed by reset and by any low-supply cycle; it counts ticks
  // only while the supply is good.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (vcc_low_i) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (hold_q && tick_i) begin
      if (cnt_q == LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/rtc_batt_guard.sv
module rtc_batt_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_low_i,
  input  logic batt_dead_i,
  input  logic batt_ok_i,
  input  logic sys_reset_i,
  output logic clr_o,
  output logic vrt_o
);
  logic clr_cond;
  logic clr_cond_q;
  logic clr_q;
  logic vcc_low_q;
  logic lost_q;
  logic vrt_q;

  assign clr_cond = batt_dead_i & sys_reset_i;

  // Edge-detected clear: one pulse per rise of the fault condition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_cond_q <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      clr_cond_q <= clr_cond;
      clr_q      <= clr_cond & ~clr_cond_q;
    end
  end

  // Battery loss during power-off is remembered until power returns.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_low_q <= 1'b0;
      lost_q    <= 1'b0;
      vrt_q     <= 1'b1;
    end else begin
      vcc_low_q <= vcc_low_i;
      if (!vcc_low_i)
        lost_q <= 1'b0;
      else if (!batt_ok_i)
        lost_q <= 1'b1;
      if (vcc_low_q && !vcc_low_i && lost_q)
        vrt_q <= 1'b0;
    end
  end

  assign clr_o = clr_q;
  assign vrt_o = vrt_q;
endmodule

// File: rtl/rtc_bus_gate.sv
module rtc_bus_gate #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] strb_i,
  input  logic         lock_i,
  output logic [N-1:0] strb_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_gate
    assign strb_o[gi] = strb_i[gi] & ~lock_i;
  end
endmodule

// File: rtl/rtc_pwr_guard.sv
module rtc_pwr_guard
  import rtc_pwr_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_low_i,
  input  logic       batt_dead_i,
  input  logic       batt_ok_i,
  input  logic       sys_reset_i,
  input  logic       host_wr_i,
  input  logic       host_rd_i,
  input  logic       tick_i,
  input  logic [2:0] div_mode_i,
  output logic       lock_o,
  output logic       wr_o,
  output logic       rd_o,
  output logic       rtc_rst_o,
  output logic       clr_regs_o,
  output logic       vrt_o
);
  logic             hold;
  logic             vrt;
  logic             div_bad;
  logic [STRB_N-1:0] strb_in;
  logic [STRB_N-1:0] strb_out;

  rtc_restore_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .vcc_low_i (vcc_low_i),
    .tick_i    (tick_i),
    .hold_o    (hold)
  );

  rtc_batt_guard u_batt (
    .clk         (clk),
    .rst_n       (rst_n),
    .vcc_low_i   (vcc_low_i),
    .batt_dead_i (batt_dead_i),
    .batt_ok_i   (batt_ok_i),
    .sys_reset_i (sys_reset_i),
    .clr_o       (clr_regs_o),
    .vrt_o       (vrt)
  );

  always_comb begin
    div_bad = (div_mode_t'(div_mode_i) != DIV_NORMAL);
    lock_o  = vcc_low_i | hold | ~vrt | div_bad;
  end

  always_comb begin
    strb_in           = '0;
    strb_in[STRB_WR]  = host_wr_i;
    strb_in[STRB_RD]  = host_rd_i;
    strb_in[STRB_RST] = sys_reset_i;
  end

  rtc_bus_gate #(.N(STRB_N)) u_gate (
    .strb_i (strb_in),
    .lock_i (lock_o),
    .strb_o (strb_out)
  );

  assign wr_o      = strb_out[STRB_WR];
  assign rd_o      = strb_out[STRB_RD];
  assign rtc_rst_o = strb_out[STRB_RST];
  assign vrt_o     = vrt;
endmodule

// File: rtl/rtc_pwr_guard_chk.sv
module rtc_pwr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_low_i,
  input logic       batt_dead_i,
  input logic       sys_reset_i,
  input logic       host_wr_i,
  input logic [2:0] div_mode_i,
  input logic       lock_o,
  input logic       wr_o,
  input logic       rd_o,
  input logic       rtc_rst_o,
  input logic       clr_regs_o,
  input logic       vrt_o
);
  // R1
  lock_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low_i |-> lock_o);

  // R2
  no_strobe_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (!wr_o && !rd_o && !rtc_rst_o));

  // R2
  wr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> (wr_o == host_wr_i));

  // R4
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_regs_o |=> !clr_regs_o);

  // R4
  clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_regs_o |-> $past(batt_dead_i && sys_reset_i));

  // R5
  vrt_fall_at_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vrt_o) |-> (!$past(vcc_low_i) && $past(vcc_low_i, 2)));

  // R6
  vrt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(vrt_o));

  // R7
  lock_on_vrt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vrt_o |-> lock_o);

  // R8
  lock_on_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_mode_i != 3'b010) |-> lock_o);
endmodule

bind rtc_pwr_guard rtc_pwr_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vcc_low_i   (vcc_low_i),
  .batt_dead_i (batt_dead_i),
  .sys_reset_i (sys_reset_i),
  .host_wr_i   (host_wr_i),
  .div_mode_i  (div_mode_i),
  .lock_o      (lock_o),
  .wr_o        (wr_o),
  .rd_o        (rd_o),
  .rtc_rst_o   (rtc_rst_o),
  .clr_regs_o  (clr_regs_o),
  .vrt_o       (vrt_o)
);

// File: tb/rtc_pwr_guard_bench.sv
`timescale 1ns/1ps
module rtc_pwr_guard_bench;
  localparam int TICK_P = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic vcc_low = 1'b0, batt_dead = 1'b0, batt_ok = 1'b1, sys_reset = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, tick = 1'b0;
  logic [2:0] div_mode = 3'b010;
  logic lock, wr, rd, rtc_rst, clr, vrt;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  rtc_pwr_guard u_rtc_pwr_guard (
    .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .batt_dead_i(batt_dead),
    .batt_ok_i(batt_ok), .sys_reset_i(sys_reset), .host_wr_i(host_wr),
    .host_rd_i(host_rd), .tick_i(tick), .div_mode_i(div_mode),
    .lock_o(lock), .wr_o(wr), .rd_o(rd), .rtc_rst_o(rtc_rst),
    .clr_regs_o(clr), .vrt_o(vrt)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Tick pulse, one cycle wide, every TICK_P cycles.
  initial forever begin
    @(negedge clk);
    tick <= ((cyc % TICK_P) == TICK_P - 1);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle_unlock();
    repeat (2 * TICK_P + 5) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(lock === 1'b1, "R3 lock in reset", lock, 1);
    chk(vrt === 1'b1, "R6 vrt after reset", vrt, 1);
    chk(clr === 1'b0, "R4 clr in reset", clr, 0);
    rst_n = 1'b1;
    settle_unlock();
    #1;
    chk(lock === 1'b0, "R3 release after reset", lock, 0);
  endtask

  task automatic wait_phase(input int ph);
    do @(negedge clk); while ((cyc % TICK_P) != ph);
  endtask

  task automatic t_passthrough();
    @(negedge clk);
    host_wr = 1'b1; host_rd = 1'b1; sys_reset = 1'b1;
    #1;
    chk(wr === 1'b1, "R2 wr pass", wr, 1);
    chk(rd === 1'b1, "R2 rd pass", rd, 1);
    chk(rtc_rst === 1'b1, "R2 rst pass", rtc_rst, 1);
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; sys_reset = 1'b0;
    #1;
    chk(wr === 1'b0, "R2 wr idle", wr, 0);
  endtask

  task automatic t_restore(input int ph);
    int n;
    int leaks;
    @(negedge clk);
    vcc_low = 1'b1; host_wr = 1'b1; host_rd = 1'b1;
    #1;
    chk(lock === 1'b1, "R1 lock on low supply", lock, 1);
    chk(wr === 1'b0 && rd === 1'b0, "R2 strobes blocked", int'(wr) + int'(rd), 0);
    wait_phase(ph);
    vcc_low = 1'b0;
    n = 0;
    leaks = 0;
    do begin
      @(negedge clk);
      #1;
      n++;
      if (lock && (wr || rd)) leaks++;
    end while (lock && n < 300);
    chk(n >= TICK_P && n <= 2 * TICK_P + 1, "R3 release window", n, 2 * TICK_P);
    chk(leaks == 0, "R2 no write during hold", leaks, 0);
    chk(vrt === 1'b1, "R6 vrt kept with good battery", vrt, 1);
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic t_clear();
    int pulses;
    @(negedge clk);
    batt_dead = 1'b1; sys_reset = 1'b0;
    pulses = 0;
    repeat (5) begin @(negedge clk); if (clr) pulses++; end
    chk(pulses == 0, "R4 no clear without reset", pulses, 0);
    sys_reset = 1'b1;
    @(negedge clk);
    chk(clr === 1'b1, "R4 clear one cycle later", clr, 1);
    pulses = 1;
    repeat (8) begin @(negedge clk); if (clr) pulses++; end
    chk(pulses == 1, "R4 single pulse while held", pulses, 1);
    sys_reset = 1'b0;
    @(negedge clk);
    sys_reset = 1'b1;
    pulses = 0;
    repeat (4) begin @(negedge clk); if (clr) pulses++; end
    chk(pulses == 1, "R4 new pulse after re-rise", pulses, 1);
    sys_reset = 1'b0; batt_dead = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_batt_removed();
    int pulses;
    @(negedge clk);
    vcc_low = 1'b1;
    repeat (3) @(negedge clk);
    batt_ok = 1'b0;
    repeat (3) @(negedge clk);
    batt_ok = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(vrt === 1'b1, "R5 vrt held until restore", vrt, 1);
    vcc_low = 1'b0;
    pulses = 0;
    @(negedge clk);
    #1;
    chk(vrt === 1'b0, "R5 vrt cleared at restore", vrt, 0);
    repeat (2 * TICK_P + 10) begin @(negedge clk); if (clr) pulses++; end
    host_wr = 1'b1;
    #1;
    chk(pulses == 0, "R5 no register clear", pulses, 0);
    chk(lock === 1'b1, "R7 lock while vrt 0", lock, 1);
    chk(wr === 1'b0, "R7 write blocked while vrt 0", wr, 0);
    chk(vrt === 1'b0, "R6 vrt stays 0", vrt, 0);
    host_wr = 1'b0;
  endtask

  task automatic t_divider();
    @(negedge clk);
    div_mode = 3'b000;
    host_wr = 1'b1;
    #1;
    chk(lock === 1'b1, "R8 lock on 000", lock, 1);
    chk(wr === 1'b0, "R8 write blocked", wr, 0);
    @(negedge clk);
    div_mode = 3'b110;
    #1;
    chk(lock === 1'b1, "R8 lock on 110", lock, 1);
    @(negedge clk);
    div_mode = 3'b010;
    #1;
    chk(lock === 1'b0, "R8 unlock on 010", lock, 0);
    host_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    t_passthrough();
    t_restore(2);
    t_restore(20);
    t_restore(38);
    t_clear();
    t_divider();
    t_batt_removed();
    do_reset();
    chk(vrt === 1'b1, "R6 reset restores vrt", vrt, 1);
    t_passthrough();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule